// File: doc/BRIEF.md
# Privileged Special Register Unit

This block keeps the supervisor-only control state of a 32-bit register-windowed processor core. It holds three registers: the processor state register, the window invalid mask and the trap base register. It watches the decoded instruction fields (major opcode, op3, destination number, source values, immediate select and 13-bit immediate) of the instruction being executed. When it sees a special-register read, it places the register value on a destination bus. When it sees a special-register write, it stores the exclusive-OR of the first source value and a second operand.

The block also owns the legality checks on these accesses. A caller in user mode is refused and flagged. A write with a nonzero destination field is flagged as illegal, and so is a state write that would select a window that does not exist. A separate trap-entry port loads the trap-type field of the trap base register. The pipeline uses the flags to raise its own traps. Trap sequencing itself is not part of this block.

Top module: `priv_sreg_unit`

## Requirements
- R1: An operation is recognised only when `op_valid` is 1 and `op` = 2. Reads use op3 0x29 (state), 0x2A (window mask) and 0x2B (trap base). Writes use op3 0x31, 0x32 and 0x33 in the same order. No other op or op3 value produces a read strobe, a write or a flag.
- R2: A write stores `rs1_val` XOR a second operand. The second operand is `rs2_val` when `imm_sel` = 0, and the sign-extended `simm13` when `imm_sel` = 1.
- R3: A state read returns the following fields. Bits 31:28 hold IMPL_ID and bits 27:24 hold VER_ID. Bits 23:14 are zero. The remaining fields are enable-coprocessor at bit 13, enable-FPU at bit 12, interrupt level at bits 11:8, supervisor at bit 7, previous-supervisor at bit 6, enable-traps at bit 5 and current window at bits 4:0. A state write loads bits 13:0 of the written value.
- R4: A trap base write changes only bits 31:12. Bits 11:4 keep the trap type, and bits 3:0 always read 0.
- R5: When `trap_load` is 1, `trap_type` is loaded into trap base bits 11:4 at the clock edge. This happens independently of any write.
- R6: A window mask read returns the stored value ANDed with (1 << NUM_WINDOWS) − 1.
- R7: A state write whose bits 4:0 are NUM_WINDOWS or more raises `illegal` and changes no register. The current window always stays below NUM_WINDOWS.
- R8: A write with `rd` ≠ 0 raises `illegal` and changes no register.
- R9: When the supervisor bit is 0, any recognised read or write raises `priv_viol`, holds `rd_wen` and `rd_data` at 0, keeps `illegal` at 0 and changes no register.
- R10: Reset sets the supervisor bit to 1 and clears all other stored fields. A state read after reset returns {IMPL_ID, VER_ID, 24'h000080}.
- R11: `rd_data`, `rd_wen`, `illegal` and `priv_viol` follow the inputs within the same cycle. Writes take effect at the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Instruction fields are valid this cycle |
| op | input | 2 | Major opcode field |
| op3 | input | 6 | Operation field |
| rd | input | 5 | Destination register number |
| rs1_val | input | 32 | Value of the first source register |
| rs2_val | input | 32 | Value of the second source register |
| imm_sel | input | 1 | Selects the immediate as the second operand |
| simm13 | input | 13 | Signed immediate field |
| trap_load | input | 1 | Trap entry: load the trap type |
| trap_type | input | 8 | Trap type to record |
| rd_data | output | 32 | Value returned by a read |
| rd_wen | output | 1 | Destination write strobe for a read |
| illegal | output | 1 | Malformed or out-of-range write |
| priv_viol | output | 1 | Access attempted outside supervisor mode |

## Verification
Read data, the read strobe and both flags come from combinational logic, so they are due in the same cycle the fields are presented. Register updates are due one rising edge later. The bench drives every operation on the falling edge and samples the combinational results 2 ns afterwards. Each write is confirmed by a read operation issued after the rising edge that commits it. Refused writes are judged the same way, by reading the register back after that edge, or by checking that the privilege state still refuses access.

// File: rtl/priv_sreg_pkg.sv
package priv_sreg_pkg;

  localparam logic [1:0] OP_ARITH   = 2'd2;
  localparam logic [5:0] OP3_RD_ST  = 6'h29;
  localparam logic [5:0] OP3_RD_WM  = 6'h2A;
  localparam logic [5:0] OP3_RD_TB  = 6'h2B;
  localparam logic [5:0] OP3_WR_ST  = 6'h31;
  localparam logic [5:0] OP3_WR_WM  = 6'h32;
  localparam logic [5:0] OP3_WR_TB  = 6'h33;

  typedef enum logic [1:0] {
    SR_NONE = 2'd0,
    SR_ST   = 2'd1,
    SR_WM   = 2'd2,
    SR_TB   = 2'd3
  } sreg_sel_e;

  // low 14 bits of the state register, MSB first
  typedef struct packed {
    logic       cp_en;
    logic       fp_en;
    logic [3:0] irq_lvl;
    logic       sup;
    logic       prev_sup;
    logic       trap_en;
    logic [4:0] win;
  } st_fields_t;

endpackage

// File: rtl/priv_sreg_decode.sv
module priv_sreg_decode
  import priv_sreg_pkg::*;
(
  input  logic        op_valid,
  input  logic [1:0]  op,
  input  logic [5:0]  op3,
  input  logic [4:0]  rd,
  input  logic [31:0] rs1_val,
  input  logic [31:0] rs2_val,
  input  logic        imm_sel,
  input  logic [12:0] simm13,
  output sreg_sel_e   rsel,
  output sreg_sel_e   wsel,
  output logic        rd_nonzero,
  output logic [31:0] wdata
);

  logic        fmt_hit;
  logic [31:0] operand2;

  assign fmt_hit    = op_valid && (op == OP_ARITH);
  assign operand2   = imm_sel ? {{19{simm13[12]}}, simm13} : rs2_val;
  assign wdata      = rs1_val ^ operand2;
  assign rd_nonzero = (rd != 5'd0);

  always_comb begin
    rsel = SR_NONE;
    wsel = SR_NONE;
    if (fmt_hit) begin
      unique case (op3)
        OP3_RD_ST: rsel = SR_ST;
        OP3_RD_WM: rsel = SR_WM;
        OP3_RD_TB: rsel = SR_TB;
        OP3_WR_ST: wsel = SR_ST;
        OP3_WR_WM: wsel = SR_WM;
        OP3_WR_TB: wsel = SR_TB;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/priv_sreg_state.sv
module priv_sreg_state
  import priv_sreg_pkg::*;
#(
  parameter int         NUM_WINDOWS = 8,
  parameter logic [3:0] IMPL_ID     = 4'h3,
  parameter logic [3:0] VER_ID      = 4'h2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic [31:0] wdata,
  output logic        win_bad,
  output logic        sup,
  output logic [31:0] rdata
);

  localparam logic [5:0] NWIN_L = 6'(NUM_WINDOWS);

  st_fields_t st_q, st_d;

  assign win_bad = ({1'b0, wdata[4:0]} >= NWIN_L);
  assign sup     = st_q.sup;
  assign rdata   = {IMPL_ID, VER_ID, 10'b0, st_q};

  always_comb begin
    st_d = st_q;
    if (we) st_d = st_fields_t'(wdata[13:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= '0;
      st_q.sup <= 1'b1;
    end else begin
      st_q <= st_d;
    end
  end

  assert_state_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (14'(st_q) == $past(wdata[13:0])));

  assert_win_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, st_q.win} < NWIN_L));

endmodule

// File: rtl/priv_sreg_tbwm.sv
module priv_sreg_tbwm #(
  parameter int NUM_WINDOWS = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tb_we,
  input  logic        wm_we,
  input  logic [31:0] wdata,
  input  logic        trap_load,
  input  logic [7:0]  trap_type,
  output logic [31:0] tb_rdata,
  output logic [31:0] wm_rdata
);

  localparam logic [31:0] WM_MASK =
    (NUM_WINDOWS >= 32) ? '1 : ((32'd1 << NUM_WINDOWS) - 32'd1);

  logic [19:0] base_q, base_d;
  logic [7:0]  tt_q,   tt_d;
  logic [31:0] wm_q,   wm_d;

  assign tb_rdata = {base_q, tt_q, 4'b0000};
  assign wm_rdata = wm_q & WM_MASK;

  always_comb begin
    base_d = base_q;
    tt_d   = tt_q;
    wm_d   = wm_q;
    if (tb_we)     base_d = wdata[31:12];
    if (trap_load) tt_d   = trap_type;
    if (wm_we)     wm_d   = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      tt_q   <= '0;
      wm_q   <= '0;
    end else begin
      base_q <= base_d;
      tt_q   <= tt_d;
      wm_q   <= wm_d;
    end
  end

  assert_base_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tb_we |=> (base_q == $past(wdata[31:12])));

  assert_tt_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_load |=> $stable(tt_q));

  assert_tt_trap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    trap_load |=> (tt_q == $past(trap_type)));

  assert_mask_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wm_we |=> (wm_q == $past(wdata)));

endmodule

// File: rtl/priv_sreg_unit.sv
module priv_sreg_unit
  import priv_sreg_pkg::*;
#(
  parameter int         NUM_WINDOWS = 8,
  parameter logic [3:0] IMPL_ID     = 4'h3,
  parameter logic [3:0] VER_ID      = 4'h2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        op_valid,
  input  logic [1:0]  op,
  input  logic [5:0]  op3,
  input  logic [4:0]  rd,
  input  logic [31:0] rs1_val,
  input  logic [31:0] rs2_val,
  input  logic        imm_sel,
  input  logic [12:0] simm13,
  input  logic        trap_load,
  input  logic [7:0]  trap_type,
  output logic [31:0] rd_data,
  output logic        rd_wen,
  output logic        illegal,
  output logic        priv_viol
);

  localparam logic [31:0] WM_MASK =
    (NUM_WINDOWS >= 32) ? '1 : ((32'd1 << NUM_WINDOWS) - 32'd1);

  sreg_sel_e   rsel, wsel;
  logic        rd_nz, win_bad, sup, wr_ok;
  logic [31:0] wdata, st_rdata, tb_rdata, wm_rdata;

  priv_sreg_decode u_dec (
    .op_valid  (op_valid),
    .op        (op),
    .op3       (op3),
    .rd        (rd),
    .rs1_val   (rs1_val),
    .rs2_val   (rs2_val),
    .imm_sel   (imm_sel),
    .simm13    (simm13),
    .rsel      (rsel),
    .wsel      (wsel),
    .rd_nonzero(rd_nz),
    .wdata     (wdata)
  );

  assign priv_viol = !sup && ((rsel != SR_NONE) || (wsel != SR_NONE));
  assign illegal   = sup && (wsel != SR_NONE) &&
                     (rd_nz || ((wsel == SR_ST) && win_bad));
  assign wr_ok     = sup && (wsel != SR_NONE) && !illegal;

  priv_sreg_state #(
    .NUM_WINDOWS(NUM_WINDOWS),
    .IMPL_ID    (IMPL_ID),
    .VER_ID     (VER_ID)
  ) u_state (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (wr_ok && (wsel == SR_ST)),
    .wdata  (wdata),
    .win_bad(win_bad),
    .sup    (sup),
    .rdata  (st_rdata)
  );

  priv_sreg_tbwm #(
    .NUM_WINDOWS(NUM_WINDOWS)
  ) u_tbwm (
    .clk      (clk),
    .rst_n    (rst_n),
    .tb_we    (wr_ok && (wsel == SR_TB)),
    .wm_we    (wr_ok && (wsel == SR_WM)),
    .wdata    (wdata),
    .trap_load(trap_load),
    .trap_type(trap_type),
    .tb_rdata (tb_rdata),
    .wm_rdata (wm_rdata)
  );

  always_comb begin
    rd_wen  = sup && (rsel != SR_NONE);
    rd_data = '0;
    if (rd_wen) begin
      unique case (rsel)
        SR_ST:   rd_data = st_rdata;
        SR_WM:   rd_data = wm_rdata;
        SR_TB:   rd_data = tb_rdata;
        default: rd_data = '0;
      endcase
    end
  end

  assert_no_leak_R9: assert property (@(posedge clk) disable iff (!rst_n)
    priv_viol |-> (!rd_wen && (rd_data == 32'd0) && !illegal));

  assert_priv_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    priv_viol |=> ($stable(st_rdata) && $stable(wm_rdata)));

  assert_illegal_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> ($stable(st_rdata) && $stable(wm_rdata)));

  assert_mask_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_wen && (rsel == SR_WM)) |-> ((rd_data & ~WM_MASK) == 32'd0));

endmodule

// File: tb/test_priv_sreg_unit.sv
module test_priv_sreg_unit;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid;
  logic [1:0]  op;
  logic [5:0]  op3;
  logic [4:0]  rd;
  logic [31:0] rs1_val, rs2_val;
  logic        imm_sel;
  logic [12:0] simm13;
  logic        trap_load;
  logic [7:0]  trap_type;
  logic [31:0] rd_data;
  logic        rd_wen, illegal, priv_viol;

  int n_vec  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  priv_sreg_unit i_priv_sreg_unit (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op(op), .op3(op3),
    .rd(rd), .rs1_val(rs1_val), .rs2_val(rs2_val), .imm_sel(imm_sel),
    .simm13(simm13), .trap_load(trap_load), .trap_type(trap_type),
    .rd_data(rd_data), .rd_wen(rd_wen), .illegal(illegal),
    .priv_viol(priv_viol)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    op_valid = 1'b0; op = 2'd0; op3 = 6'd0; rd = 5'd0;
    rs1_val = '0; rs2_val = '0; imm_sel = 1'b0; simm13 = '0;
    trap_load = 1'b0; trap_type = '0;
  endtask

  task automatic drive(input logic [1:0] o, input logic [5:0] o3, input logic [4:0] r,
                       input logic [31:0] a, input logic [31:0] b,
                       input logic im, input logic [12:0] s13);
    op_valid = 1'b1; op = o; op3 = o3; rd = r;
    rs1_val = a; rs2_val = b; imm_sel = im; simm13 = s13;
  endtask

  // read: sampled in the same cycle, before the next rising edge
  task automatic rd_op(input logic [5:0] o3, output logic [31:0] v,
                       output logic we, output logic pv);
    drive(2'd2, o3, 5'd9, 32'h0, 32'h0, 1'b0, 13'h0);
    #2;
    v = rd_data; we = rd_wen; pv = priv_viol;
    @(negedge clk); idle();
  endtask

  // write: flags sampled before the edge, effect visible after it
  task automatic wr_op(input logic [5:0] o3, input logic [4:0] r,
                       input logic [31:0] a, input logic [31:0] b,
                       input logic im, input logic [12:0] s13,
                       output logic il, output logic pv);
    drive(2'd2, o3, r, a, b, im, s13);
    #2;
    il = illegal; pv = priv_viol;
    @(negedge clk); idle();
  endtask

  task automatic do_reset();
    idle();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v; logic we, pv;
    do_reset();
    rd_op(6'h29, v, we, pv); chk("R10 state after reset", v, 32'h3200_0080);
    chk("R10 read strobe", {31'b0, we}, 32'd1);
    rd_op(6'h2A, v, we, pv); chk("R10 mask after reset", v, 32'h0);
    rd_op(6'h2B, v, we, pv); chk("R10 base after reset", v, 32'h0);
  endtask

  task automatic t_decode();
    drive(2'd3, 6'h29, 5'd1, 32'h0, 32'h0, 1'b0, 13'h0); #2;
    chk("R1 wrong op no strobe", {31'b0, rd_wen}, 32'd0);
    chk("R1 wrong op no data", rd_data, 32'd0);
    @(negedge clk);
    drive(2'd2, 6'h30, 5'd0, 32'hFFFF_FFFF, 32'h0, 1'b0, 13'h0); #2;
    chk("R1 unknown op3 flags", {29'b0, rd_wen, illegal, priv_viol}, 32'd0);
    @(negedge clk);
    drive(2'd2, 6'h33, 5'd0, 32'hFFFF_FFFF, 32'h0, 1'b0, 13'h0);
    op_valid = 1'b0; #2;
    @(negedge clk); idle();
    begin
      logic [31:0] v; logic we, pv;
      rd_op(6'h2B, v, we, pv); chk("R1 invalid write ignored", v, 32'h0);
    end
  endtask

  task automatic t_state();
    logic [31:0] v; logic we, pv, il;
    wr_op(6'h31, 5'd0, 32'hFFFF_2F00, 32'hFFFF_00A3, 1'b0, 13'h0, il, pv);
    chk("R11 legal write no flag", {30'b0, il, pv}, 32'd0);
    rd_op(6'h29, v, we, pv); chk("R3 state fields xor rs2", v, 32'h3200_2FA3);
    wr_op(6'h31, 5'd0, 32'h0000_0080, 32'h0, 1'b1, 13'h0027, il, pv);
    rd_op(6'h29, v, we, pv); chk("R2 state xor imm, window 7 legal", v, 32'h3200_00A7);
  endtask

  task automatic t_mask();
    logic [31:0] v; logic we, pv, il;
    wr_op(6'h32, 5'd0, 32'hFFFF_FF00, 32'h0, 1'b1, 13'h1FFF, il, pv);
    rd_op(6'h2A, v, we, pv); chk("R2 mask xor sign-extended imm", v, 32'h0000_00FF);
    wr_op(6'h32, 5'd0, 32'h0, 32'hFFFF_0F0F, 1'b0, 13'h0, il, pv);
    rd_op(6'h2A, v, we, pv); chk("R6 mask read trimmed", v, 32'h0000_000F);
  endtask

  task automatic t_base();
    logic [31:0] v; logic we, pv, il;
    trap_load = 1'b1; trap_type = 8'hA5;
    @(negedge clk); idle();
    rd_op(6'h2B, v, we, pv); chk("R5 trap type loaded", v, 32'h0000_0A50);
    wr_op(6'h33, 5'd0, 32'h1234_5678, 32'h0, 1'b0, 13'h0, il, pv);
    rd_op(6'h2B, v, we, pv); chk("R4 base write keeps trap type", v, 32'h1234_5A50);
    wr_op(6'h33, 5'd0, 32'h0000_0FFF, 32'h0, 1'b1, 13'h1000, il, pv);
    rd_op(6'h2B, v, we, pv); chk("R4 base imm write, low nibble 0", v, 32'hFFFF_FA50);
  endtask

  task automatic t_illegal();
    logic [31:0] v; logic we, pv, il;
    wr_op(6'h31, 5'd0, 32'h0000_0080, 32'h0000_0008, 1'b0, 13'h0, il, pv);
    chk("R7 window 8 flagged", {31'b0, il}, 32'd1);
    rd_op(6'h29, v, we, pv); chk("R7 state unchanged", v, 32'h3200_00A7);
    wr_op(6'h32, 5'd3, 32'hFFFF_FFFF, 32'h0, 1'b0, 13'h0, il, pv);
    chk("R8 nonzero rd flagged", {31'b0, il}, 32'd1);
    rd_op(6'h2A, v, we, pv); chk("R8 mask unchanged", v, 32'h0000_000F);
  endtask

  task automatic t_priv();
    logic [31:0] v; logic we, pv, il;
    wr_op(6'h31, 5'd0, 32'h0, 32'h0, 1'b0, 13'h0, il, pv);
    rd_op(6'h29, v, we, pv);
    chk("R9 user read flagged", {31'b0, pv}, 32'd1);
    chk("R9 user read no strobe", {31'b0, we}, 32'd0);
    chk("R9 user read no data", v, 32'd0);
    wr_op(6'h31, 5'd0, 32'h0000_0080, 32'h0, 1'b0, 13'h0, il, pv);
    chk("R9 user write flags", {30'b0, pv, il}, 32'd2);
    rd_op(6'h29, v, we, pv); chk("R9 user write had no effect", {31'b0, pv}, 32'd1);
    do_reset();
    rd_op(6'h29, v, we, pv); chk("R10 reset restores supervisor", v, 32'h3200_0080);
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    idle();
    rst_n = 1'b0;
    @(negedge clk);
    t_reset();
    t_decode();
    t_state();
    t_mask();
    t_base();
    t_illegal();
    t_priv();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule